// File: doc/BRIEF.md
# Fine-Grained Label Egress Decapsulator

This block rewrites one egress port's frame stream, one byte per cycle. Each incoming frame starts at its inner destination MAC address, because the outer link header has already been removed. The block looks at the type field that follows the two inner MAC addresses. When that field is 0x893B, the frame carries a fine-grained label split across two extended tags. When it is 0x8100, the frame carries an ordinary VLAN label. Any other value marks the frame as malformed.

For a labelled frame, the block joins the two 12-bit label halves into a 24-bit label and looks the label up in a small per-port table to find the output VLAN ID. It then removes both 4-byte extended tags. In their place it inserts either one standard 0x8100 tag, or nothing when the port is set to strip tags. The inserted tag takes its priority and drop-eligible bit from the second extended tag. Ordinary VLAN frames pass through unchanged. Malformed frames, and labelled frames whose label has no table entry, are not sent out at all.

While a frame is still arriving, a sideband reports its label, its transport priority and drop-eligible bit (taken from the first tag) and its class. Queueing and flooding logic uses these values.

Top module: `fgl_egress_decap`

## Requirements
- R1: During and directly after reset, `out_valid` and `sb_valid` are 0.
- R2: Bytes 12-13 of a frame (first byte high) select its class, reported on `sb_class`. 0x893B gives 2 (labelled) and 0x8100 gives 1 (VLAN). Any other value gives 3 (malformed), and a malformed frame produces no output bytes and keeps `sb_valid` at 0.
- R3: A labelled frame whose bytes 16-17 are not 0x893B is reported as class 3 and is dropped.
- R4: For a labelled frame, `sb_label` is {bits 11:0 of the tag in bytes 14-15, bits 11:0 of the tag in bytes 18-19}. `sb_pri` is bits 15:13 of the bytes 14-15 tag and `sb_dei` is its bit 12.
- R5: The lookup uses only enabled entries whose label equals the frame's label. Among those, the lowest entry index gives the output VLAN ID.
- R6: With `cfg_strip` at 0, a labelled frame leaves as bytes 0-11, then 0x81 and 0x00, then a tag control word {bits 15:12 of the bytes 18-19 tag, mapped VID}, then the payload. The frame is 4 bytes shorter.
- R7: With `cfg_strip` at 1, a labelled frame leaves as bytes 0-11 followed by the payload. The frame is 8 bytes shorter.
- R8: A labelled frame whose label matches no enabled entry produces no output bytes.
- R9: A VLAN-class frame leaves byte for byte unchanged. Its sideband label is {12'h000, tag bits 11:0}, with priority and drop-eligible bit taken from the tag in bytes 14-15.
- R10: Each output byte appears 21 cycles after its input byte. `sb_valid` rises in the cycle after byte 19 of a labelled frame, or after byte 15 of a VLAN frame. It falls in the cycle after the end-of-frame byte.
- R11: Frames are contiguous and at least 21 bytes long, and they may follow one another with no idle cycle between them. Each frame is handled as it would be on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| in_data | input | 8 | Input byte |
| cfg_strip | input | 1 | 1: emit untagged frames; 0: insert a 0x8100 tag |
| cfg_map_en | input | N_MAP | Enable bit for each map entry |
| cfg_map_label | input | 24*N_MAP | 24-bit label for each entry; entry i is at bits [24i +: 24] |
| cfg_map_vid | input | 12*N_MAP | Output VLAN ID for each entry; entry i is at bits [12i +: 12] |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is the first byte of a frame |
| out_eof | output | 1 | Output byte is the last byte of a frame |
| out_data | output | 8 | Output byte |
| sb_valid | output | 1 | Sideband label, priority and drop-eligible bit are valid |
| sb_label | output | 24 | Label of the current frame |
| sb_pri | output | 3 | Transport priority |
| sb_dei | output | 1 | Transport drop-eligible bit |
| sb_class | output | 2 | 0 none, 1 VLAN, 2 labelled, 3 malformed |

## Verification
Output bytes come 21 cycles after the matching input byte. The bench records the cycle in which it drives each frame's first byte and the cycle in which the matching first output byte is seen, and requires the gap to be exactly 21. Sideband values are registered. The bench reads them on the falling edge while driving byte 19 (expected still low for labelled frames), while driving byte 20 (expected to carry the frame's values), and on the first falling edge after the end-of-frame byte (expected low). Output bytes are collected for 30 cycles after each frame or frame pair, which is more than the pipeline latency, and then compared with the expected rewritten frame.

// File: rtl/fgl_pkg.sv
package fgl_pkg;
    localparam int LBL_W  = 24;
    localparam int HALF_W = 12;
    localparam int VID_W  = 12;
    localparam int IDX_W  = 5;
    localparam int HDR_BYTES = 20;

    localparam logic [15:0] TYPE_FGL  = 16'h893B;
    localparam logic [15:0] TYPE_VLAN = 16'h8100;

    // byte offsets inside a frame, counted from the inner destination MAC
    localparam logic [IDX_W-1:0] BY_TY1_HI  = 5'd12;
    localparam logic [IDX_W-1:0] BY_TY1_LO  = 5'd13;
    localparam logic [IDX_W-1:0] BY_TAG1_HI = 5'd14;
    localparam logic [IDX_W-1:0] BY_TAG1_LO = 5'd15;
    localparam logic [IDX_W-1:0] BY_TY2_HI  = 5'd16;
    localparam logic [IDX_W-1:0] BY_TY2_LO  = 5'd17;
    localparam logic [IDX_W-1:0] BY_TAG2_HI = 5'd18;
    localparam logic [IDX_W-1:0] BY_TAG2_LO = 5'd19;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_VLAN = 2'd1,
        CL_FGL  = 2'd2,
        CL_BAD  = 2'd3
    } class_e;

    typedef enum logic [1:0] {
        ACT_DROP  = 2'd0,
        ACT_PASS  = 2'd1,
        ACT_TAG   = 2'd2,
        ACT_UNTAG = 2'd3
    } act_e;

    typedef struct packed {
        act_e        act;
        logic [15:0] tci;
    } dec_t;

    typedef struct packed {
        logic             v;
        logic             sof;
        logic             eof;
        logic [7:0]       d;
        logic [IDX_W-1:0] idx;
    } beat_t;
endpackage

// File: rtl/fgl_label_map.sv
module fgl_label_map
    import fgl_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic [LBL_W-1:0]       key,
    input  logic [N_ENT-1:0]       cfg_en,
    input  logic [N_ENT*LBL_W-1:0] cfg_label,
    input  logic [N_ENT*VID_W-1:0] cfg_vid,
    output logic                   hit,
    output logic [VID_W-1:0]       vid
);
    localparam int SEL_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [N_ENT-1:0] match;
    logic [SEL_W-1:0] sel;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = cfg_en[g] && (cfg_label[g*LBL_W +: LBL_W] == key);
    end

    // lowest matching index wins
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                sel = i[SEL_W-1:0];
            end
        end
    end

    assign vid = cfg_vid[sel*VID_W +: VID_W];

    always_comb begin
        if (hit) begin
            // R5
            map_pick_chk: assert (cfg_en[sel] && cfg_label[sel*LBL_W +: LBL_W] == key);
            for (int j = 0; j < N_ENT; j++) begin
                if (j < int'(sel)) begin
                    // R5
                    map_prio_chk: assert (!(cfg_en[j] && cfg_label[j*LBL_W +: LBL_W] == key));
                end
            end
        end
    end
endmodule

// File: rtl/fgl_hdr_parse.sv
module fgl_hdr_parse
    import fgl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic             cfg_strip,
    input  logic             map_hit,
    input  logic [VID_W-1:0] map_vid,
    output logic [IDX_W-1:0] byte_idx,
    output logic [LBL_W-1:0] key,
    output dec_t             dec,
    output logic             sb_valid,
    output logic [LBL_W-1:0] sb_label,
    output logic [2:0]       sb_pri,
    output logic             sb_dei,
    output class_e           sb_class
);
    typedef struct packed {
        logic [IDX_W-1:0] cnt;
        logic [7:0]       ty1_hi;
        logic [15:0]      tag1;
        logic [7:0]       ty2_hi;
        logic [7:0]       tag2_hi;
        class_e           cls;
        logic             sbv;
        logic [LBL_W-1:0] lbl;
        logic [2:0]       pri;
        logic             dei;
        dec_t             dec;
    } st_t;

    st_t st_d, st_q;
    logic [IDX_W-1:0] idx;

    always_comb begin
        st_d = st_q;
        idx  = in_sof ? '0 : st_q.cnt;
        key  = {st_q.tag1[HALF_W-1:0], st_q.tag2_hi[3:0], in_data};
        if (in_valid) begin
            st_d.cnt = (idx == '1) ? idx : idx + 1'b1;
            case (idx)
                BY_TY1_HI:  st_d.ty1_hi = in_data;
                BY_TY1_LO: begin
                    if ({st_q.ty1_hi, in_data} == TYPE_FGL) begin
                        st_d.cls = CL_FGL;
                    end else if ({st_q.ty1_hi, in_data} == TYPE_VLAN) begin
                        st_d.cls = CL_VLAN;
                    end else begin
                        st_d.cls     = CL_BAD;
                        st_d.dec.act = ACT_DROP;
                    end
                end
                BY_TAG1_HI: st_d.tag1[15:8] = in_data;
                BY_TAG1_LO: begin
                    st_d.tag1[7:0] = in_data;
                    if (st_q.cls == CL_VLAN) begin
                        st_d.sbv     = 1'b1;
                        st_d.lbl     = {{(LBL_W-HALF_W){1'b0}}, st_q.tag1[11:8], in_data};
                        st_d.pri     = st_q.tag1[15:13];
                        st_d.dei     = st_q.tag1[12];
                        st_d.dec.act = ACT_PASS;
                        st_d.dec.tci = {st_q.tag1[15:8], in_data};
                    end
                end
                BY_TY2_HI:  st_d.ty2_hi = in_data;
                BY_TY2_LO: begin
                    if (st_q.cls == CL_FGL && {st_q.ty2_hi, in_data} != TYPE_FGL) begin
                        st_d.cls     = CL_BAD;
                        st_d.dec.act = ACT_DROP;
                    end
                end
                BY_TAG2_HI: st_d.tag2_hi = in_data;
                BY_TAG2_LO: begin
                    if (st_q.cls == CL_FGL) begin
                        st_d.sbv     = 1'b1;
                        st_d.lbl     = key;
                        st_d.pri     = st_q.tag1[15:13];
                        st_d.dei     = st_q.tag1[12];
                        st_d.dec.tci = {st_q.tag2_hi[7:4], map_vid};
                        st_d.dec.act = !map_hit  ? ACT_DROP :
                                       cfg_strip ? ACT_UNTAG : ACT_TAG;
                    end
                end
                default: ;
            endcase
            if (in_eof) begin
                st_d.sbv = 1'b0;
                st_d.cls = CL_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_idx = idx;
    assign dec      = st_q.dec;
    assign sb_valid = st_q.sbv;
    assign sb_label = st_q.lbl;
    assign sb_pri   = st_q.pri;
    assign sb_dei   = st_q.dei;
    assign sb_class = st_q.cls;

    // R2
    sb_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_valid |-> (sb_class == CL_VLAN || sb_class == CL_FGL));

    // R10
    sb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sb_valid) |-> $past(in_valid) &&
            ($past(idx) == BY_TAG1_LO || $past(idx) == BY_TAG2_LO));

    // R10
    sb_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sb_valid) |-> $past(in_valid && in_eof));
endmodule

// File: rtl/fgl_delay_line.sv
module fgl_delay_line
    import fgl_pkg::*;
#(
    parameter int DEPTH = HDR_BYTES
) (
    input  logic  clk,
    input  logic  rst_n,
    input  beat_t in_beat,
    output beat_t tail
);
    beat_t [DEPTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = in_beat;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign tail = stage_q[DEPTH-1];
endmodule

// File: rtl/fgl_tag_rewrite.sv
module fgl_tag_rewrite
    import fgl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  beat_t      tail,
    input  dec_t       dec,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_eof,
    output logic [7:0] out_data
);
    typedef struct packed {
        dec_t       cur;
        logic       v;
        logic       sof;
        logic       eof;
        logic [7:0] d;
    } st_t;

    st_t  st_d, st_q;
    dec_t cur_c;
    logic in_hdr, in_newtag;

    always_comb begin
        cur_c     = (tail.v && tail.sof) ? dec : st_q.cur;
        in_hdr    = (tail.idx >= BY_TY1_HI) && (tail.idx <= BY_TAG2_LO);
        in_newtag = (tail.idx >= BY_TY1_HI) && (tail.idx <= BY_TAG1_LO);
        st_d      = st_q;
        st_d.cur  = cur_c;
        st_d.d    = tail.d;
        st_d.v    = 1'b0;
        if (tail.v) begin
            case (cur_c.act)
                ACT_PASS:  st_d.v = 1'b1;
                ACT_UNTAG: st_d.v = !in_hdr;
                ACT_TAG: begin
                    st_d.v = !in_hdr || in_newtag;
                    case (tail.idx)
                        BY_TY1_HI:  st_d.d = TYPE_VLAN[15:8];
                        BY_TY1_LO:  st_d.d = TYPE_VLAN[7:0];
                        BY_TAG1_HI: st_d.d = cur_c.tci[15:8];
                        BY_TAG1_LO: st_d.d = cur_c.tci[7:0];
                        default: ;
                    endcase
                end
                default:   st_d.v = 1'b0;
            endcase
        end
        st_d.sof = tail.sof && st_d.v;
        st_d.eof = tail.eof && st_d.v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v;
    assign out_sof   = st_q.sof;
    assign out_eof   = st_q.eof;
    assign out_data  = st_q.d;

    // R8
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail.v && cur_c.act == ACT_DROP |=> !out_valid);

    // R10
    sof_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail.v && tail.sof && cur_c.act != ACT_DROP |=> out_valid && out_sof);

    // R6
    tag_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail.v && cur_c.act == ACT_TAG && tail.idx >= BY_TY2_HI && tail.idx <= BY_TAG2_LO
        |=> !out_valid);
endmodule

// File: rtl/fgl_egress_decap.sv
module fgl_egress_decap
    import fgl_pkg::*;
#(
    parameter int N_MAP = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic                   in_eof,
    input  logic [7:0]             in_data,
    input  logic                   cfg_strip,
    input  logic [N_MAP-1:0]       cfg_map_en,
    input  logic [N_MAP*LBL_W-1:0] cfg_map_label,
    input  logic [N_MAP*VID_W-1:0] cfg_map_vid,
    output logic                   out_valid,
    output logic                   out_sof,
    output logic                   out_eof,
    output logic [7:0]             out_data,
    output logic                   sb_valid,
    output logic [LBL_W-1:0]       sb_label,
    output logic [2:0]             sb_pri,
    output logic                   sb_dei,
    output logic [1:0]             sb_class
);
    localparam int DELAY = HDR_BYTES;

    logic [IDX_W-1:0] byte_idx;
    logic [LBL_W-1:0] key;
    logic             map_hit;
    logic [VID_W-1:0] map_vid;
    dec_t             dec;
    class_e           cls;
    beat_t            in_beat, tail;

    fgl_hdr_parse u_parse (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_data  (in_data),
        .cfg_strip(cfg_strip),
        .map_hit  (map_hit),
        .map_vid  (map_vid),
        .byte_idx (byte_idx),
        .key      (key),
        .dec      (dec),
        .sb_valid (sb_valid),
        .sb_label (sb_label),
        .sb_pri   (sb_pri),
        .sb_dei   (sb_dei),
        .sb_class (cls)
    );

    fgl_label_map #(.N_ENT(N_MAP)) u_map (
        .key      (key),
        .cfg_en   (cfg_map_en),
        .cfg_label(cfg_map_label),
        .cfg_vid  (cfg_map_vid),
        .hit      (map_hit),
        .vid      (map_vid)
    );

    assign in_beat = '{v: in_valid, sof: in_sof, eof: in_eof, d: in_data, idx: byte_idx};

    fgl_delay_line #(.DEPTH(DELAY)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_beat(in_beat),
        .tail   (tail)
    );

    fgl_tag_rewrite u_rewrite (
        .clk      (clk),
        .rst_n    (rst_n),
        .tail     (tail),
        .dec      (dec),
        .out_valid(out_valid),
        .out_sof  (out_sof),
        .out_eof  (out_eof),
        .out_data (out_data)
    );

    assign sb_class = cls;
endmodule

// File: tb/sim_fgl_egress_decap.sv
module sim_fgl_egress_decap;
    localparam int N = 4;
    localparam int LAT = 21;

    typedef struct packed {
        logic [15:0] ty1;
        logic [15:0] t1;
        logic [15:0] ty2;
        logic [15:0] t2;
        logic        strip;
        logic [7:0]  plen;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h893B, 16'hA123, 16'h893B, 16'h5456, 1'b0, 8'd4},  // tagged, duplicate entries
        '{16'h893B, 16'h6ABC, 16'h893B, 16'hE001, 1'b1, 8'd6},  // stripped
        '{16'h893B, 16'h2777, 16'h893B, 16'h3777, 1'b0, 8'd3},  // disabled entry: miss
        '{16'h8100, 16'h4064, 16'h0800, 16'h4500, 1'b0, 8'd8},  // plain VLAN
        '{16'h0800, 16'h4500, 16'h0000, 16'h0000, 1'b0, 8'd5},  // malformed first type
        '{16'h893B, 16'hA123, 16'h8100, 16'h5456, 1'b0, 8'd5},  // malformed second type
        '{16'h893B, 16'hA123, 16'h893B, 16'h5456, 1'b0, 8'd1},  // minimum length
        '{16'h893B, 16'h0ABC, 16'h893B, 16'h1001, 1'b0, 8'd7}   // tagged, top VID
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic cfg_strip = 1'b0;
    logic [N-1:0]    cfg_map_en    = 4'b0111;
    logic [N*24-1:0] cfg_map_label = {24'h777777, 24'hABC001, 24'h123456, 24'h123456};
    logic [N*12-1:0] cfg_map_vid   = {12'h055, 12'hFFE, 12'h0B0, 12'h00A};
    logic out_valid, out_sof, out_eof;
    logic [7:0] out_data;
    logic sb_valid, sb_dei;
    logic [23:0] sb_label;
    logic [2:0] sb_pri;
    logic [1:0] sb_class;

    fgl_egress_decap #(.N_MAP(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .cfg_strip(cfg_strip), .cfg_map_en(cfg_map_en),
        .cfg_map_label(cfg_map_label), .cfg_map_vid(cfg_map_vid),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
        .sb_valid(sb_valid), .sb_label(sb_label), .sb_pri(sb_pri), .sb_dei(sb_dei),
        .sb_class(sb_class)
    );

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] got[$];
    logic [7:0] expq[$];
    int got_t[$];
    int exp_t[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got.push_back(out_data);
            if (out_sof) got_t.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (cyc == 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual %0d cycles expected fewer than 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic bit model_lookup(input logic [23:0] lbl, output logic [11:0] vid);
        vid = 12'h000;
        for (int i = 0; i < N; i++) begin
            if (cfg_map_en[i] && cfg_map_label[i*24 +: 24] == lbl) begin
                vid = cfg_map_vid[i*12 +: 12];
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic send_frame(input vec_t v, input int seed, output string rq);
        logic [7:0] fr[$];
        logic [7:0] ex[$];
        bit is_fgl, is_vlan, bad, fwd, hit;
        logic [11:0] vid;
        logic [15:0] tci;
        logic [23:0] lbl;
        logic [30:0] sb_exp, sb_act;
        for (int k = 0; k < 12; k++) fr.push_back(8'(k * 7 + seed * 3 + 1));
        fr.push_back(v.ty1[15:8]); fr.push_back(v.ty1[7:0]);
        fr.push_back(v.t1[15:8]);  fr.push_back(v.t1[7:0]);
        fr.push_back(v.ty2[15:8]); fr.push_back(v.ty2[7:0]);
        fr.push_back(v.t2[15:8]);  fr.push_back(v.t2[7:0]);
        for (int j = 0; j < int'(v.plen); j++) fr.push_back(8'(8'h40 + seed * 16 + j));

        is_fgl  = (v.ty1 == 16'h893B);
        is_vlan = (v.ty1 == 16'h8100);
        bad     = (!is_fgl && !is_vlan) || (is_fgl && v.ty2 != 16'h893B);
        lbl     = {v.t1[11:0], v.t2[11:0]};
        fwd     = 1'b0;
        rq      = is_fgl ? "R3" : "R2";
        sb_exp  = {1'b0, 2'd3, 28'h0};
        if (is_vlan) begin
            fwd = 1'b1;
            rq  = "R9";
            ex  = fr;
            sb_exp = {1'b1, 2'd1, 12'h000, v.t1[11:0], v.t1[15:13], v.t1[12]};
        end else if (!bad) begin
            sb_exp = {1'b1, 2'd2, lbl, v.t1[15:13], v.t1[12]};
            hit = model_lookup(lbl, vid);
            if (!hit) begin
                rq = "R8";
            end else begin
                fwd = 1'b1;
                for (int k = 0; k < 12; k++) ex.push_back(fr[k]);
                if (v.strip) begin
                    rq = "R7";
                end else begin
                    rq  = "R5/R6";
                    tci = {v.t2[15:12], vid};
                    ex.push_back(8'h81); ex.push_back(8'h00);
                    ex.push_back(tci[15:8]); ex.push_back(tci[7:0]);
                end
                for (int k = 20; k < fr.size(); k++) ex.push_back(fr[k]);
            end
        end

        for (int k = 0; k < fr.size(); k++) begin
            @(negedge clk);
            if (k == 0) cfg_strip = v.strip;
            in_valid = 1'b1;
            in_sof   = (k == 0);
            in_eof   = (k == fr.size() - 1);
            in_data  = fr[k];
            if (k == 0) begin
                // R10: previous frame's sideband already cleared
                check(sb_valid == 1'b0, "R10", "sideband low at frame start", 64'(sb_valid), 64'h0);
                if (fwd) exp_t.push_back(cyc);
            end
            if (k == 19 && is_fgl && !bad)
                check(sb_valid == 1'b0, "R10", "sideband not yet valid at byte 19", 64'(sb_valid), 64'h0);
            if (k == 20) begin
                sb_act = {sb_valid, sb_class, bad ? 28'h0 : {sb_label, sb_pri, sb_dei}};
                // R4 for labelled frames, class code for others
                check(sb_act == sb_exp, (is_fgl && !bad) ? "R4" : rq, "sideband", 64'(sb_act), 64'(sb_exp));
            end
        end
        foreach (ex[i]) expq.push_back(ex[i]);
    endtask

    task automatic drain(input string rq);
        int mism;
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        check(sb_valid == 1'b0, "R10", "sideband low after end of frame", 64'(sb_valid), 64'h0);
        repeat (30) @(negedge clk);
        check(got.size() == expq.size(), rq, "output byte count", 64'(got.size()), 64'(expq.size()));
        mism = -1;
        if (got.size() == expq.size()) begin
            for (int i = got.size() - 1; i >= 0; i--) if (got[i] !== expq[i]) mism = i;
        end
        if (mism >= 0)
            check(1'b0, rq, $sformatf("output byte %0d", mism), 64'(got[mism]), 64'(expq[mism]));
        else
            check(1'b1, rq, "output bytes", 64'h0, 64'h0);
        check(got_t.size() == exp_t.size(), "R10", "forwarded frame count", 64'(got_t.size()), 64'(exp_t.size()));
        if (got_t.size() == exp_t.size()) begin
            foreach (got_t[i])
                check(got_t[i] - exp_t[i] == LAT, "R10", "first byte latency",
                      64'(got_t[i] - exp_t[i]), 64'(LAT));
        end
        got.delete();
        expq.delete();
        got_t.delete();
        exp_t.delete();
    endtask

    initial begin
        string rq;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0 && sb_valid == 1'b0, "R1", "outputs during reset",
              64'({out_valid, sb_valid}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && sb_valid == 1'b0 && sb_class == 2'd0, "R1", "outputs after reset",
              64'({out_valid, sb_valid, sb_class}), 64'h0);

        for (int i = 0; i < NV; i++) begin
            send_frame(VECS[i], i, rq);
            drain(rq);
        end

        // R11: back-to-back frames with no idle cycle
        send_frame(VECS[0], 8, rq);
        send_frame(VECS[7], 9, rq);
        drain("R11");

        // R11: forwarded frame right after a dropped one
        send_frame(VECS[2], 10, rq);
        send_frame(VECS[3], 11, rq);
        drain("R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule